// File: doc/BRIEF.md
# Linear Sweep Ramp Generator

This block produces the offset that a direct digital synthesizer adds to its frequency or phase word while it sweeps linearly. A 32-bit auxiliary accumulator moves from a start value toward an end value, one programmed delta per step. A down-counting ramp-rate timer sets the time between steps. A trigger pin picks the direction. A 2-bit destination field tells the downstream datapath whether the value is a frequency offset or a phase offset.

The sweep value is a continuously driven level, not a stream. It is a register output that the consumer may sample on any cycle, so it has no valid/ready pair and no back-pressure. All control inputs are plain levels except `io_update`, which is a single-cycle strobe.

Top module: `sweep_ramp_gen`

## Requirements
- R1: `is_phase` is 1 exactly when `dest` is 2'b01. The codes 2'b00, 2'b10 and 2'b11 report a frequency offset (`is_phase` = 0).
- R2: While `sweep_en` or `acc_en` is 0, `sweep_val` takes `start_val` at every clock edge and `done` is 0. `trig_in`, `no_dwell` and `state_trig` have no effect during that time.
- R3: `trig_in` is registered once. The registered level gives the direction: 1 sweeps upward toward `end_val`, and 0 sweeps downward toward `start_val`. Any change of the registered level starts a new sweep and clears `done` one edge later.
- R4: With `no_dwell` = 0, the step that reaches the limit of the current direction sets `done`. After that, `sweep_val` holds until the next trigger change.
- R5: With `no_dwell` = 1, a step that would reach the limit loads the initial value of that sweep instead: `start_val` when going up, `end_val` when going down. In edge mode (`state_trig` = 0) this sets `done` and stepping stops. In state mode (`state_trig` = 1) `done` stays 0 and the ramp repeats.
- R6: `sweep_val` never passes `end_val` when going up or `start_val` when going down. When the remaining span is smaller than `delta`, the step lands exactly on the limit.
- R7: While the block is inactive, the timer loads `ramp_rate`. After activation, the first step occurs on edge `ramp_rate`+1, and each later step follows `ramp_rate`+1 edges after the previous one.
- R8: With `load_at_upd` = 0, a new `ramp_rate` takes effect only when the running count reaches zero, and `io_update` leaves the timer alone.
- R9: With `load_at_upd` = 1, an `io_update` reloads the timer with `ramp_rate` at that edge. The next step then occurs `ramp_rate`+1 edges later.
- R10: An `io_update` with `autoclear` = 1 loads zero into the accumulator at that edge, and stepping then resumes from zero. With `autoclear` = 0, an `io_update` leaves `sweep_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_en | input | 1 | Linear sweep enable |
| acc_en | input | 1 | Auxiliary accumulator enable |
| dest | input | 2 | Destination: 00 frequency, 01 phase |
| no_dwell | input | 1 | Snap back to the initial value at the end of a sweep |
| state_trig | input | 1 | 0 = edge mode, 1 = state mode |
| load_at_upd | input | 1 | Reload the timer on `io_update` |
| autoclear | input | 1 | Clear the accumulator on `io_update` |
| start_val | input | ACC_W | Lower sweep limit |
| end_val | input | ACC_W | Upper sweep limit |
| delta | input | ACC_W | Step size |
| ramp_rate | input | RATE_W | Timer reload; step interval minus one |
| trig_in | input | 1 | Sweep direction trigger |
| io_update | input | 1 | Register-transfer strobe |
| sweep_val | output | ACC_W | Current accumulator value |
| is_phase | output | 1 | Value is a phase offset |
| done | output | 1 | Sweep has finished |

## Verification
The bench builds the block with ACC_W = 32 and RATE_W = 4. The full accumulator width lets a sweep end just below 2^32, which shows that the clamp never wraps. The narrow timer makes a maximum-rate interval only sixteen cycles long, so the largest reload value is timed exactly. A zero rate reaches the case of one step on every edge. All step-timing checks count edges from a known timer phase after activation. This makes the mid-count rate change and the reload on update observable to the cycle.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    DEST_FREQ  = 2'b00,
    DEST_PHASE = 2'b01,
    DEST_RSV2  = 2'b10,
    DEST_RSV3  = 2'b11
  } sweep_dest_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/sweep_trig_ctrl.sv
module sweep_trig_ctrl
  import sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  output sweep_dir_e dir,
  output logic       trig_event
);
  logic trig_q;
  logic trig_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      trig_prev <= 1'b0;
    end else begin
      trig_q    <= trig_in;
      trig_prev <= trig_q;
    end
  end

  // Direction follows the registered level; any change marks a new sweep.
  assign dir        = trig_q ? DIR_UP : DIR_DOWN;
  assign trig_event = trig_q ^ trig_prev;
endmodule

// File: rtl/sweep_rate_timer.sv
module sweep_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              running,
  input  logic              io_update,
  input  logic              load_at_upd,
  input  logic [RATE_W-1:0] ramp_rate,
  output logic              tick
);
  logic [RATE_W-1:0] cnt_q;
  logic              zero;

  assign zero = (cnt_q == '0);
  assign tick = running && zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= ramp_rate;
    end else if (io_update && load_at_upd) begin
      cnt_q <= ramp_rate;
    end else if (running) begin
      if (zero) cnt_q <= ramp_rate;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sweep_step_calc.sv
module sweep_step_calc
  import sweep_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] lo_lim,
  input  logic [ACC_W-1:0] hi_lim,
  input  logic [ACC_W-1:0] delta,
  input  sweep_dir_e       dir,
  output logic [ACC_W-1:0] next_val,
  output logic             at_limit
);
  logic [ACC_W-1:0] gap_up;
  logic [ACC_W-1:0] gap_dn;
  logic             reach_up;
  logic             reach_dn;

  assign gap_up   = hi_lim - acc;
  assign gap_dn   = acc - lo_lim;
  assign reach_up = (acc >= hi_lim) || (gap_up <= delta);
  assign reach_dn = (acc <= lo_lim) || (gap_dn <= delta);

  // A step is only added when the remaining gap exceeds delta, so no wrap.
  always_comb begin
    if (dir == DIR_UP) begin
      at_limit = reach_up;
      next_val = reach_up ? hi_lim : acc + delta;
    end else begin
      at_limit = reach_dn;
      next_val = reach_dn ? lo_lim : acc - delta;
    end
  end
endmodule

// File: rtl/sweep_aux_acc.sv
module sweep_aux_acc
  import sweep_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             clear_hit,
  input  logic             tick,
  input  logic             trig_event,
  input  logic             no_dwell,
  input  logic             state_trig,
  input  sweep_dir_e       dir,
  input  logic [ACC_W-1:0] start_val,
  input  logic [ACC_W-1:0] end_val,
  input  logic [ACC_W-1:0] delta,
  output logic [ACC_W-1:0] acc,
  output logic             done
);
  logic [ACC_W-1:0] acc_q;
  logic             done_q;
  logic [ACC_W-1:0] next_val;
  logic             at_limit;
  logic [ACC_W-1:0] snap_val;

  sweep_step_calc #(.ACC_W(ACC_W)) u_step (
    .acc      (acc_q),
    .lo_lim   (start_val),
    .hi_lim   (end_val),
    .delta    (delta),
    .dir      (dir),
    .next_val (next_val),
    .at_limit (at_limit)
  );

  assign snap_val = (dir == DIR_UP) ? start_val : end_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else if (!active) begin
      acc_q  <= start_val;
      done_q <= 1'b0;
    end else if (clear_hit) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (tick) begin
        if (at_limit && no_dwell) acc_q <= snap_val;
        else                      acc_q <= next_val;
      end
      if (trig_event)            done_q <= 1'b0;
      else if (tick && at_limit) done_q <= !(no_dwell && state_trig);
    end
  end

  assign acc  = acc_q;
  assign done = done_q;
endmodule

// File: rtl/sweep_ramp_gen.sv
module sweep_ramp_gen
  import sweep_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_en,
  input  logic              acc_en,
  input  logic [1:0]        dest,
  input  logic              no_dwell,
  input  logic              state_trig,
  input  logic              load_at_upd,
  input  logic              autoclear,
  input  logic [ACC_W-1:0]  start_val,
  input  logic [ACC_W-1:0]  end_val,
  input  logic [ACC_W-1:0]  delta,
  input  logic [RATE_W-1:0] ramp_rate,
  input  logic              trig_in,
  input  logic              io_update,
  output logic [ACC_W-1:0]  sweep_val,
  output logic              is_phase,
  output logic              done
);
  logic       active;
  logic       running;
  logic       clear_hit;
  logic       tick;
  logic       trig_event;
  sweep_dir_e dir;

  assign active    = sweep_en && acc_en;
  assign running   = active && !done;
  assign clear_hit = active && autoclear && io_update;
  assign is_phase  = (sweep_dest_e'(dest) == DEST_PHASE);

  sweep_trig_ctrl u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_in    (trig_in),
    .dir        (dir),
    .trig_event (trig_event)
  );

  sweep_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .running     (running),
    .io_update   (io_update),
    .load_at_upd (load_at_upd),
    .ramp_rate   (ramp_rate),
    .tick        (tick)
  );

  sweep_aux_acc #(.ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .clear_hit  (clear_hit),
    .tick       (tick),
    .trig_event (trig_event),
    .no_dwell   (no_dwell),
    .state_trig (state_trig),
    .dir        (dir),
    .start_val  (start_val),
    .end_val    (end_val),
    .delta      (delta),
    .acc        (sweep_val),
    .done       (done)
  );
endmodule

// File: rtl/sweep_ramp_gen_chk.sv
module sweep_ramp_gen_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sweep_en,
  input logic             acc_en,
  input logic             autoclear,
  input logic             io_update,
  input logic             trig_event,
  input logic [ACC_W-1:0] start_val,
  input logic [ACC_W-1:0] end_val,
  input logic [ACC_W-1:0] sweep_val,
  input logic             done
);
  // R2: an inactive block tracks the start value and reports not done
  p_idle_tracks_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_en && acc_en) |=> (sweep_val == $past(start_val)) && !done);

  // R4: a finished sweep with no new trigger and no update keeps its value
  p_hold_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sweep_en && acc_en && !trig_event && !io_update) |=> $stable(sweep_val));

  // R6: the value never climbs above the upper limit
  p_no_overshoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_val <= end_val && sweep_val <= end_val) |=> (sweep_val <= $past(end_val)));

  // R10: update with autoclear zeroes the accumulator at that edge
  p_autoclear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && acc_en && autoclear && io_update) |=> (sweep_val == '0));
endmodule

bind sweep_ramp_gen sweep_ramp_gen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sweep_en   (sweep_en),
  .acc_en     (acc_en),
  .autoclear  (autoclear),
  .io_update  (io_update),
  .trig_event (trig_event),
  .start_val  (start_val),
  .end_val    (end_val),
  .sweep_val  (sweep_val),
  .done       (done)
);

// File: tb/sweep_ramp_gen_tb.sv
module sweep_ramp_gen_tb;
  localparam int ACC_W  = 32;
  localparam int RATE_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sweep_en, acc_en, no_dwell, state_trig, load_at_upd, autoclear;
  logic [1:0]        dest;
  logic [ACC_W-1:0]  start_val, end_val, delta;
  logic [RATE_W-1:0] ramp_rate;
  logic              trig_in, io_update;
  logic [ACC_W-1:0]  sweep_val;
  logic              is_phase, done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  sweep_ramp_gen #(.ACC_W(ACC_W), .RATE_W(RATE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .acc_en(acc_en), .dest(dest),
    .no_dwell(no_dwell), .state_trig(state_trig), .load_at_upd(load_at_upd),
    .autoclear(autoclear), .start_val(start_val), .end_val(end_val), .delta(delta),
    .ramp_rate(ramp_rate), .trig_in(trig_in), .io_update(io_update),
    .sweep_val(sweep_val), .is_phase(is_phase), .done(done)
  );

  task automatic chk(input string req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Disable, configure, settle, then enable on a falling edge.
  task automatic restart(input logic st, input logic nd, input logic ld, input logic [RATE_W-1:0] rate,
                         input logic [ACC_W-1:0] s, input logic [ACC_W-1:0] e,
                         input logic [ACC_W-1:0] d, input logic tr);
    sweep_en = 1'b0; acc_en = 1'b1; state_trig = st; no_dwell = nd; load_at_upd = ld;
    autoclear = 1'b0; io_update = 1'b0; ramp_rate = rate;
    start_val = s; end_val = e; delta = d; trig_in = tr;
    edges(3);
    sweep_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R2 reset value", sweep_val, '0);
    chk("R2 reset done", {31'd0, done}, 0);
    chk("R1 reset flag", {31'd0, is_phase}, 0);
  endtask

  task automatic t_dest();
    dest = 2'b00; #1; chk("R1 dest 00", {31'd0, is_phase}, 0);
    dest = 2'b01; #1; chk("R1 dest 01", {31'd0, is_phase}, 1);
    dest = 2'b10; #1; chk("R1 dest 10", {31'd0, is_phase}, 0);
    dest = 2'b11; #1; chk("R1 dest 11", {31'd0, is_phase}, 0);
    @(negedge clk);
  endtask

  task automatic t_inactive();
    sweep_en = 1'b0; acc_en = 1'b1; start_val = 32'd77; end_val = 32'd200; delta = 32'd5;
    edges(1);
    chk("R2 follows start", sweep_val, 32'd77);
    trig_in = 1'b1; edges(1); trig_in = 1'b0; no_dwell = 1'b1; state_trig = 1'b1;
    edges(1); trig_in = 1'b1; edges(2);
    chk("R2 trigger ignored", sweep_val, 32'd77);
    chk("R2 done low", {31'd0, done}, 0);
    sweep_en = 1'b1; acc_en = 1'b0; start_val = 32'd66;
    edges(4);
    chk("R2 acc_en off", sweep_val, 32'd66);
  endtask

  task automatic t_up_then_down();
    restart(1'b0, 1'b0, 1'b0, 4'd3, 32'd100, 32'd135, 32'd10, 1'b1);
    edges(3);  chk("R7 before first step", sweep_val, 32'd100);
    edges(1);  chk("R7 first step", sweep_val, 32'd110);
    edges(4);  chk("R7 second step", sweep_val, 32'd120);
    edges(4);  chk("R3 up step", sweep_val, 32'd130);
    chk("R4 not done yet", {31'd0, done}, 0);
    edges(4);  chk("R6 clamp at end", sweep_val, 32'd135);
    chk("R4 done set", {31'd0, done}, 1);
    edges(8);  chk("R4 holds", sweep_val, 32'd135);
    trig_in = 1'b0;
    edges(5);  chk("R3 no step before restart", sweep_val, 32'd135);
    edges(1);  chk("R3 first down step", sweep_val, 32'd125);
    chk("R3 done cleared", {31'd0, done}, 0);
    edges(8);  chk("R3 down step", sweep_val, 32'd105);
    edges(4);  chk("R6 clamp at start", sweep_val, 32'd100);
    chk("R4 done down", {31'd0, done}, 1);
  endtask

  task automatic t_nodwell_edge();
    restart(1'b0, 1'b1, 1'b0, 4'd3, 32'd100, 32'd135, 32'd10, 1'b1);
    edges(12); chk("R5 edge pre-snap", sweep_val, 32'd130);
    edges(4);  chk("R5 edge snap to start", sweep_val, 32'd100);
    chk("R5 edge done", {31'd0, done}, 1);
    edges(8);  chk("R5 edge stays", sweep_val, 32'd100);
  endtask

  task automatic t_nodwell_state();
    restart(1'b1, 1'b1, 1'b0, 4'd3, 32'd100, 32'd135, 32'd10, 1'b1);
    edges(16); chk("R5 state snap", sweep_val, 32'd100);
    chk("R5 state done low", {31'd0, done}, 0);
    edges(4);  chk("R5 state repeats", sweep_val, 32'd110);
  endtask

  task automatic t_autoclear();
    restart(1'b0, 1'b0, 1'b0, 4'd3, 32'd100, 32'd135, 32'd10, 1'b1);
    edges(2); autoclear = 1'b1; io_update = 1'b1;
    edges(1); io_update = 1'b0; autoclear = 1'b0;
    chk("R10 cleared", sweep_val, '0);
    edges(1); chk("R10 resumes from zero", sweep_val, 32'd10);
  endtask

  task automatic t_rate_deferred();
    restart(1'b0, 1'b0, 1'b0, 4'd3, 32'd100, 32'd135, 32'd10, 1'b1);
    edges(2); ramp_rate = 4'd9; io_update = 1'b1;
    edges(1); io_update = 1'b0;
    edges(1); chk("R8 old count completes", sweep_val, 32'd110);
    edges(9); chk("R8 new interval not early", sweep_val, 32'd110);
    edges(1); chk("R8 new interval", sweep_val, 32'd120);
  endtask

  task automatic t_rate_reload();
    restart(1'b0, 1'b0, 1'b1, 4'd3, 32'd100, 32'd135, 32'd10, 1'b1);
    edges(2); ramp_rate = 4'd9; io_update = 1'b1;
    edges(1); io_update = 1'b0;
    chk("R10 update without clear", sweep_val, 32'd100);
    edges(1); chk("R9 old step cancelled", sweep_val, 32'd100);
    edges(8); chk("R9 before reloaded step", sweep_val, 32'd100);
    edges(1); chk("R9 reloaded step", sweep_val, 32'd110);
  endtask

  task automatic t_corners();
    restart(1'b0, 1'b0, 1'b0, 4'd0, 32'hFFFF_FF00, 32'hFFFF_FFF0, 32'h80, 1'b1);
    edges(1); chk("R7 zero rate step", sweep_val, 32'hFFFF_FF80);
    edges(1); chk("R6 no wrap at top", sweep_val, 32'hFFFF_FFF0);
    chk("R6 done at top", {31'd0, done}, 1);
    restart(1'b0, 1'b0, 1'b0, 4'd15, 32'd0, 32'd1000, 32'd7, 1'b1);
    edges(15); chk("R7 max rate not early", sweep_val, 32'd0);
    edges(1);  chk("R7 max rate step", sweep_val, 32'd7);
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; sweep_en = 1'b0; acc_en = 1'b0; dest = 2'b00; no_dwell = 1'b0;
    state_trig = 1'b0; load_at_upd = 1'b0; autoclear = 1'b0; start_val = '0;
    end_val = '0; delta = '0; ramp_rate = '0; trig_in = 1'b0; io_update = 1'b0;
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(1);
    t_dest();
    t_inactive();
    t_up_then_down();
    t_nodwell_edge();
    t_nodwell_state();
    t_autoclear();
    t_rate_deferred();
    t_rate_reload();
    t_corners();
    summary();
  end
endmodule